// File: doc/BRIEF.md
# Block-Sum Frame Downscaler with Per-Frame Level Normalisation

This block reduces a raster-ordered greyscale pixel stream to a small square grid of 4-bit levels, for use by a compact classifier. A square window of the frame, placed at fixed column and row offsets, is cut into equal square blocks. The intensities of the pixels in each block are summed. Pixels outside the window do not contribute to any sum.

The block collects every block sum of the frame and tracks the smallest and largest sums as it goes. It then runs a post-pass over the stored sums. Each sum is mapped onto 0..15 relative to that frame's own range, using a short sequential divider. The result is turned upside down, so that dark strokes on a light background become high levels. Weak levels under a programmable threshold are cleared, which suppresses uneven background shading. The post-pass writes each level into an external result buffer through a write address, data and enable, and signals the end with a one-cycle done pulse.

A pixel is accepted only when its valid flag is high. The start-of-frame flag travels with the first pixel of a frame and restarts all accumulation. By default the frame is 640x480 and the grid is 28x28 blocks of 17x17 pixels, offset 82 columns and 2 rows. All of these sizes are parameters.

Top module: `frame_downscaler`

## Requirements
- R1: The level for block (bx, by) is written to address by*GRID + bx. Its sum covers the BLK x BLK pixels at columns X_OFF + bx*BLK + j and rows Y_OFF + by*BLK + i, for i and j from 0 to BLK-1. Columns and rows count from 0 at the start-of-frame pixel, and each row is IMG_W accepted pixels long.
- R2: Pixels outside the window are ignored, whatever their value. The window covers columns X_OFF .. X_OFF+GRID*BLK-1 and rows Y_OFF .. Y_OFF+GRID*BLK-1.
- R3: The scaled level of a sum s is floor((s - mn) * 15 / (mx - mn)), where mn and mx are the smallest and largest block sums of the same frame.
- R4: The written value is 15 minus the scaled level, unless R5 clears it.
- R5: A value from R4 that is below `thresh` is written as 0. A value equal to or above `thresh` is written unchanged. `thresh` = 0 clears nothing.
- R6: When all block sums of a frame are equal, every scaled level is 0, so every written value is 15.
- R7: After a frame, exactly GRID*GRID writes occur, at addresses 0, 1, ... GRID*GRID-1 in that order. `frame_done` is high for exactly one cycle, in the cycle after the write to the last address.
- R8: A pixel that carries `sof` restarts accumulation. Pixels of an earlier, incomplete frame do not affect the results. A start of frame that arrives during the post-pass abandons that post-pass before any further write.
- R9: After reset, `wr_en` and `frame_done` are low until a frame has been completed.
- R10: While `pix_valid` is low, `pix` and `sof` have no effect, and the position within the frame does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix | input | PIX_W | Greyscale intensity of the current pixel |
| pix_valid | input | 1 | The current pixel is valid |
| sof | input | 1 | The current pixel is the first of a frame |
| thresh | input | 4 | Written values below this level are cleared |
| wr_addr | output | clog2(GRID*GRID) | Result buffer address |
| wr_data | output | 4 | Result level |
| wr_en | output | 1 | Result buffer write strobe |
| frame_done | output | 1 | One-cycle pulse after the last result write |

## Verification
A wrong column or row counter, or a block accumulator that is not cleared, shifts sums between neighbouring cells. That error also moves the frame's minimum or maximum, so most of the grid's levels change. These errors therefore show up in the first frame's result writes, within a few cycles of the post-pass. A fault in the divider or in the inversion shows up in individual cell values. A fault in sequencing shows up as a missing, extra or misplaced write, or as a done pulse in the wrong cycle. A stale-state fault appears only after a truncated frame or an interrupted post-pass. For that reason, those sequences are followed by a full frame whose every value is compared.

// File: rtl/frame_downscaler.sv
module frame_downscaler #(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int PIX_W = 8,
  parameter int BLK   = 17,
  parameter int GRID  = 28,
  parameter int X_OFF = 82,
  parameter int Y_OFF = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [PIX_W-1:0]                 pix,
  input  logic                             pix_valid,
  input  logic                             sof,
  input  logic [3:0]                       thresh,
  output logic [$clog2(GRID*GRID)-1:0]     wr_addr,
  output logic [3:0]                       wr_data,
  output logic                             wr_en,
  output logic                             frame_done
);
  localparam int SPAN  = GRID * BLK;
  localparam int CELLS = GRID * GRID;
  localparam int AW    = $clog2(CELLS);
  localparam int SW    = $clog2(BLK * BLK * ((1 << PIX_W) - 1) + 1);
  localparam int NW    = SW + 4;
  localparam int CW    = $clog2(IMG_W + 1);
  localparam int RW    = $clog2(IMG_H + 1);
  localparam int BW    = $clog2(BLK + 1);
  localparam int GW    = $clog2(GRID + 1);
  localparam int XI    = (GRID > 1) ? $clog2(GRID) : 1;

  typedef enum logic [1:0] {S_RUN, S_LOAD, S_DIV, S_OUT} st_t;

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [BW-1:0] xin, yin;
  logic [GW-1:0] bx, by;
  logic [SW-1:0] acc [GRID];
  logic [SW-1:0] sum_mem [CELLS];
  logic [SW-1:0] mn, mx, den;
  logic [NW-1:0] num;
  logic [AW-1:0] idx;
  logic [3:0]    q;
  logic [1:0]    k;
  logic          fin;
  st_t           state;

  wire fs = pix_valid & sof;
  wire [CW-1:0] c_col = fs ? '0 : col;
  wire [RW-1:0] c_row = fs ? '0 : row;
  wire [BW-1:0] xin_c = fs ? '0 : xin;
  wire [BW-1:0] yin_c = fs ? '0 : yin;
  wire [GW-1:0] bx_c  = fs ? '0 : bx;
  wire [GW-1:0] by_c  = fs ? '0 : by;

  wire in_x   = c_col >= CW'(X_OFF) && c_col < CW'(X_OFF + SPAN);
  wire in_y   = c_row >= RW'(Y_OFF) && c_row < RW'(Y_OFF + SPAN);
  wire hit    = pix_valid && in_x && in_y;
  wire eol    = c_col == CW'(IMG_W - 1);
  wire last_x = xin_c == BW'(BLK - 1);
  wire last_y = yin_c == BW'(BLK - 1);
  wire blk_end = hit && last_x && last_y;
  wire [XI-1:0] bsel = bx_c[XI-1:0];
  wire [AW-1:0] cidx = AW'(by_c) * AW'(GRID) + AW'(bx_c);
  wire [SW-1:0] asum = (fs ? '0 : acc[bsel]) + SW'(pix);
  wire [3:0]    inv  = 4'd15 - q;
  wire [NW-1:0] dsh  = NW'(den) << k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0; row <= '0; xin <= '0; yin <= '0; bx <= '0; by <= '0;
    end else if (pix_valid) begin
      col <= eol ? '0 : c_col + 1'b1;
      row <= eol ? c_row + 1'b1 : c_row;
      if (eol) begin
        xin <= '0; bx <= '0;
      end else if (in_x) begin
        if (last_x) begin xin <= '0; bx <= bx_c + 1'b1; end
        else xin <= xin_c + 1'b1;
      end else begin
        xin <= xin_c; bx <= bx_c;
      end
      if (eol && in_y) begin
        if (last_y) begin yin <= '0; by <= by_c + 1'b1; end
        else yin <= yin_c + 1'b1;
      end else begin
        yin <= yin_c; by <= by_c;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < GRID; i++) acc[i] <= '0;
    end else begin
      if (fs)
        for (int i = 0; i < GRID; i++) acc[i] <= '0;
      if (hit) acc[bsel] <= (last_x && last_y) ? '0 : asum;
    end
  end

  always_ff @(posedge clk) begin
    if (blk_end) sum_mem[cidx] <= asum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RUN; idx <= '0; num <= '0; den <= '0; q <= '0; k <= '0;
      mn <= '0; mx <= '0; fin <= 1'b0; frame_done <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      fin <= 1'b0;
      frame_done <= fin;
      if (blk_end) begin
        if (cidx == '0) begin
          mn <= asum; mx <= asum;
        end else begin
          if (asum < mn) mn <= asum;
          if (asum > mx) mx <= asum;
        end
      end
      case (state)
        S_RUN: if (blk_end && cidx == AW'(CELLS - 1)) begin
          state <= S_LOAD; idx <= '0;
        end
        S_LOAD: begin
          num <= NW'(sum_mem[idx] - mn) * NW'(15);
          den <= mx - mn;
          q <= '0; k <= 2'd3;
          state <= S_DIV;
        end
        S_DIV: begin
          if (den != '0 && num >= dsh) begin
            num <= num - dsh;
            q[k] <= 1'b1;
          end
          if (k == 2'd0) state <= S_OUT;
          else k <= k - 1'b1;
        end
        S_OUT: begin
          wr_en <= 1'b1;
          wr_addr <= idx;
          wr_data <= (inv < thresh) ? 4'd0 : inv;
          if (idx == AW'(CELLS - 1)) begin
            state <= S_RUN; fin <= 1'b1;
          end else begin
            idx <= idx + 1'b1; state <= S_LOAD;
          end
        end
        default: state <= S_RUN;
      endcase
      if (fs) state <= S_RUN;
    end
  end

  p_range_ordered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_RUN) |-> (mn <= mx));
  p_quot_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OUT && den != '0) |-> (num < NW'(den)));
  p_flat_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OUT && den == '0) |-> (q == 4'd0));
  p_thresh_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data == 4'd0 || wr_data >= $past(thresh)));
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(wr_en) && $past(wr_addr) == AW'(CELLS - 1)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  p_no_write_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && !fin) |=> !frame_done);
endmodule

// File: tb/tb_frame_downscaler.sv
module tb_frame_downscaler;
  localparam int CLK_P = 10;
  localparam int IMG_W = 24;
  localparam int IMG_H = 20;
  localparam int PIX_W = 8;
  localparam int BLK   = 3;
  localparam int GRID  = 4;
  localparam int X_OFF = 5;
  localparam int Y_OFF = 2;
  localparam int CELLS = GRID * GRID;
  localparam int AW    = $clog2(CELLS);

  logic clk = 0, rst_n = 0;
  logic [PIX_W-1:0] pix = '0;
  logic pix_valid = 0, sof = 0;
  logic [3:0] thresh = '0;
  logic [AW-1:0] wr_addr;
  logic [3:0] wr_data;
  logic wr_en, frame_done;

  frame_downscaler #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W), .BLK(BLK),
    .GRID(GRID), .X_OFF(X_OFF), .Y_OFF(Y_OFF)) dut (
    .clk(clk), .rst_n(rst_n), .pix(pix), .pix_valid(pix_valid), .sof(sof),
    .thresh(thresh), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .frame_done(frame_done));

  always #(CLK_P/2) clk = ~clk;

  int img [IMG_H][IMG_W];
  int exp_v [CELLS];
  int got [CELLS];
  int ncmp = 0, nerr = 0, nwr = 0, ndone = 0, cyc = 0;
  bit prev_last = 0;

  task automatic chk(string req, int act, int expv);
    ncmp++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nerr++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done) begin
        ndone++;
        chk("R7 done follows last write", int'(prev_last), 1);
      end
      if (wr_en) begin
        chk("R7 write order", int'(wr_addr), nwr % CELLS);
        got[wr_addr] = int'(wr_data);
        nwr++;
      end
      prev_last = wr_en && (wr_addr == AW'(CELLS - 1));
    end
  end

  task automatic model(int thr);
    int s [CELLS];
    int mn, mx, q, v;
    for (int by = 0; by < GRID; by++)
      for (int bx = 0; bx < GRID; bx++) begin
        s[by*GRID+bx] = 0;
        for (int i = 0; i < BLK; i++)
          for (int j = 0; j < BLK; j++)
            s[by*GRID+bx] += img[Y_OFF+by*BLK+i][X_OFF+bx*BLK+j];
      end
    mn = s[0]; mx = s[0];
    for (int c = 0; c < CELLS; c++) begin
      if (s[c] < mn) mn = s[c];
      if (s[c] > mx) mx = s[c];
    end
    for (int c = 0; c < CELLS; c++) begin
      q = (mx == mn) ? 0 : ((s[c] - mn) * 15) / (mx - mn);
      v = 15 - q;
      exp_v[c] = (v < thr) ? 0 : v;
    end
  endtask

  task automatic fill(int lo, int hi, int outside);
    for (int r = 0; r < IMG_H; r++)
      for (int c = 0; c < IMG_W; c++) begin
        if (outside >= 0 && (c < X_OFF || c >= X_OFF+GRID*BLK ||
            r < Y_OFF || r >= Y_OFF+GRID*BLK))
          img[r][c] = outside;
        else
          img[r][c] = lo + int'($urandom % (hi - lo + 1));
      end
  endtask

  task automatic send(int npix, bit gaps);
    for (int p = 0; p < npix; p++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        pix_valid = 0; sof = 1'($urandom); pix = PIX_W'($urandom);
      end
      @(negedge clk);
      pix_valid = 1; sof = (p == 0); pix = PIX_W'(img[p / IMG_W][p % IMG_W]);
    end
    @(negedge clk);
    pix_valid = 0; sof = 0;
  endtask

  task automatic finish_frame(string req, int thr);
    int w = 0;
    model(thr);
    while (ndone == 0 && w < 2000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    chk({req, " write count"}, nwr, CELLS);
    chk({req, " done count"}, ndone, 1);
    for (int c = 0; c < CELLS; c++) chk({req, " cell value"}, got[c], exp_v[c]);
  endtask

  task automatic begin_frame(int thr);
    thresh = 4'(thr);
    nwr = 0; ndone = 0;
    for (int c = 0; c < CELLS; c++) got[c] = -1;
  endtask

  initial begin
    int thr;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R9 wr_en in reset", int'(wr_en), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R9 wr_en after reset", int'(wr_en), 0);
    chk("R9 frame_done after reset", int'(frame_done), 0);

    // R1 R3 R4: plain random frame without gaps
    begin_frame(6); fill(0, 255, -1); send(IMG_W*IMG_H, 0);
    finish_frame("R1/R3/R4", 6);

    // R6: flat frame gives all 15
    begin_frame(9); fill(100, 100, -1); send(IMG_W*IMG_H, 1);
    finish_frame("R6", 9);

    // R2 and R5 with thresh 0: bright surround must not matter
    begin_frame(0); fill(0, 40, 255); send(IMG_W*IMG_H, 1);
    finish_frame("R2 R5", 0);

    // R5 with thresh 15 and R10 gaps carrying junk sof
    begin_frame(15); fill(0, 255, 0); send(IMG_W*IMG_H, 1);
    finish_frame("R5 R10", 15);

    // R8: truncated frame then full frame
    begin_frame(4); fill(200, 255, -1); send(150, 1);
    fill(0, 255, -1); send(IMG_W*IMG_H, 1);
    finish_frame("R8 truncated", 4);

    // R8: new frame arrives during post-pass
    begin_frame(3); fill(0, 255, -1);
    send((Y_OFF+GRID*BLK-1)*IMG_W + X_OFF+GRID*BLK, 0);
    fill(0, 255, 7); send(IMG_W*IMG_H, 1);
    finish_frame("R8 abort", 3);

    for (int n = 0; n < 6; n++) begin
      thr = int'($urandom % 16);
      begin_frame(thr);
      if (n % 2 == 0) fill(0, 3, -1); else fill(0, 255, -1);
      send(IMG_W*IMG_H, 1);
      finish_frame("R1/R3/R4/R5 random", thr);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule